// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog down-counter for a small controller. Once software turns it on, it counts down from a fixed period on every clock. Software restarts the count by writing an ordered pair of key bytes to a restart register. If the count runs out while the watchdog is on, the block drives a reset request of fixed length to the chip's reset sequencer. It also latches an overflow flag, so that code running after the reset can tell that the watchdog caused it.

Software reaches the block over a minimal register bus with a one-bit address, an eight-bit write-data byte, a write strobe and a combinational read-data byte. The reset sequencer feeds every system reset back in on `sys_rst`. That reset turns the watchdog off and clears any half-entered key. It leaves the overflow flag alone, which only power-on reset or software can clear.

Top module: `kwd_top`

## Requirements
- R1: Address 0 is the control register: bit 0 is the enable bit, bit 1 is the overflow flag, and bits 7..2 read 0. Address 1 is the restart register; it reads as 0x00.
- R2: After power-on reset (`por_n` low), the enable bit and the overflow flag are 0 and `wd_rst_pulse` is low.
- R3: A control write that sets bit 0 while the watchdog is off loads the counter with TIMEOUT. `wd_rst_pulse` then rises on the TIMEOUT+1-th clock edge after the write edge, unless a restart or disable intervenes.
- R4: While the enable bit is 0 the counter holds its value and no pulse starts, however long the wait.
- R5: Writing 0x1E to the restart register and then 0xE1 to it, as the next restart write, reloads the counter with TIMEOUT at the edge of the 0xE1 write.
- R6: No reload happens in three cases: any byte other than 0xE1 that follows an armed 0x1E, a 0xE1 with no armed 0x1E before it, and a second 0x1E, which disarms. Each of these returns the sequence to waiting for 0x1E; for example, 0x1E, 0x1E, 0xE1 gives no reload.
- R7: `wd_rst_pulse` stays high for exactly 16 consecutive cycles per timeout, and asserting `sys_rst` during the pulse does not shorten it.
- R8: The overflow flag reads 1 from the first cycle of the timeout pulse.
- R9: `sys_rst` does not clear the overflow flag. A control write with bit 1 = 0 clears it, power-on reset clears it, and a write with bit 1 = 1 never sets it.
- R10: A cycle with `sys_rst` high clears the enable bit and discards an armed 0x1E.
- R11: While the pulse is high, the counter is frozen and restart keys and enable writes do not reload it. If the enable bit is still 1 when the pulse ends, a new pulse starts after exactly one low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| sys_rst | input | 1 | Synchronous system reset from the reset sequencer, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 control, 1 restart |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for the register selected by `addr` |
| wd_rst_pulse | output | 1 | Watchdog reset request to the reset sequencer |

## Verification
The properties assume that the reset sequencer answers a timeout pulse by asserting `sys_rst`. They also assume that the counter only ever moves upward through a bus write, because every load path starts at `wr_en`. The stimulus drives all bus and reset inputs half a cycle away from the sampling edge. It asserts `sys_rst` on the first observed pulse cycle, except in the one case that deliberately leaves the enable bit set, so that the back-to-back refire can be observed. The sweeps vary the key bytes over all 256 values with a short period, so that each trial completes in a few dozen cycles.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
    localparam int unsigned DATA_W    = 8;
    localparam logic [7:0]  KEY_FIRST = 8'h1E;
    localparam logic [7:0]  KEY_LAST  = 8'hE1;
    localparam logic        ADDR_CTRL = 1'b0;
    localparam logic        ADDR_KICK = 1'b1;

    typedef struct packed {
        logic en;
        logic ovf;
    } ctl_t;
endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst,
    input  logic       kick_wr,
    input  logic [7:0] kick_data,
    output logic       reload
);
    typedef struct packed {
        logic armed;
    } key_st_t;

    key_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        reload = 1'b0;
        if (sys_rst) begin
            st_d.armed = 1'b0;
        end else if (kick_wr) begin
            if (st_q.armed && kick_data == KEY_LAST) begin
                reload     = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.armed = !st_q.armed && (kick_data == KEY_FIRST);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int unsigned TIMEOUT = 4000,
    localparam int unsigned CW     = $clog2(TIMEOUT + 1)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          load,
    input  logic          run,
    output logic [CW-1:0] count,
    output logic          expired
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)
            st_d.cnt = CW'(TIMEOUT);
        else if (run && st_q.cnt != '0)
            st_d.cnt = st_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{cnt: CW'(TIMEOUT)};
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign expired = (st_q.cnt == '0);
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int unsigned PULSE_LEN = 16,
    localparam int unsigned PW       = $clog2(PULSE_LEN + 1)
) (
    input  logic clk,
    input  logic por_n,
    input  logic fire,
    output logic active
);
    typedef struct packed {
        logic [PW-1:0] left;
    } pls_st_t;

    pls_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.left != '0)
            st_d.left = st_q.left - PW'(1);
        else if (fire)
            st_d.left = PW'(PULSE_LEN);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.left != '0);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int unsigned TIMEOUT   = 4000,
    parameter int unsigned PULSE_LEN = 16,
    localparam int unsigned CW       = $clog2(TIMEOUT + 1)
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst,
    input  logic       wr_en,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       wd_rst_pulse
);
    ctl_t ctl_d, ctl_q;

    logic          ctl_wr, kick_wr, en_rise;
    logic          key_reload, cnt_load, cnt_run, cnt_zero, fire;
    logic [CW-1:0] cnt_val;
    logic          wd_en, wd_ovf;

    assign ctl_wr  = wr_en && (addr == ADDR_CTRL);
    assign kick_wr = wr_en && (addr == ADDR_KICK);

    kwd_keyseq u_keyseq (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst   (sys_rst),
        .kick_wr   (kick_wr),
        .kick_data (wdata),
        .reload    (key_reload)
    );

    kwd_counter #(.TIMEOUT(TIMEOUT)) u_counter (
        .clk     (clk),
        .por_n   (por_n),
        .load    (cnt_load),
        .run     (cnt_run),
        .count   (cnt_val),
        .expired (cnt_zero)
    );

    kwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk    (clk),
        .por_n  (por_n),
        .fire   (fire),
        .active (wd_rst_pulse)
    );

    always_comb begin
        ctl_d    = ctl_q;
        en_rise  = ctl_wr && wdata[0] && !ctl_q.en && !sys_rst;
        fire     = ctl_q.en && cnt_zero && !wd_rst_pulse;
        cnt_load = !wd_rst_pulse && (en_rise || key_reload);
        cnt_run  = ctl_q.en && !wd_rst_pulse;

        if (sys_rst)
            ctl_d.en = 1'b0;
        else if (ctl_wr)
            ctl_d.en = wdata[0];

        if (fire)
            ctl_d.ovf = 1'b1;
        else if (ctl_wr && !wdata[1])
            ctl_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wd_en  = ctl_q.en;
    assign wd_ovf = ctl_q.ovf;
    assign rdata  = (addr == ADDR_CTRL) ? {6'b0, ctl_q.ovf, ctl_q.en} : 8'h00;
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk #(
    parameter int unsigned PULSE_LEN = 16,
    parameter int unsigned CW        = 12
) (
    input logic          clk,
    input logic          por_n,
    input logic          sys_rst,
    input logic          wr_en,
    input logic          wd_en,
    input logic          wd_ovf,
    input logic [CW-1:0] cnt_val,
    input logic          wd_rst_pulse
);
    logic [7:0] run_len;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)            run_len <= '0;
        else if (wd_rst_pulse) run_len <= run_len + 8'd1;
        else                   run_len <= '0;
    end

    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wd_rst_pulse) |-> (run_len == 8'(PULSE_LEN)));

    assert_pulse_cap_R7: assert property (@(posedge clk) disable iff (!por_n)
        run_len <= 8'(PULSE_LEN));

    assert_flag_on_fire_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wd_rst_pulse) |-> wd_ovf);

    assert_quiet_when_off_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!wd_en && !wd_rst_pulse) |=> !wd_rst_pulse);

    assert_sysrst_disables_R10: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> !wd_en);

    assert_frozen_in_pulse_R11: assert property (@(posedge clk) disable iff (!por_n)
        wd_rst_pulse |=> $stable(cnt_val));

    assert_no_reload_unwritten_R5: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> (cnt_val <= $past(cnt_val)));
endmodule

bind kwd_top kwd_chk #(.PULSE_LEN(PULSE_LEN), .CW(CW)) u_kwd_chk (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst      (sys_rst),
    .wr_en        (wr_en),
    .wd_en        (wd_en),
    .wd_ovf       (wd_ovf),
    .cnt_val      (cnt_val),
    .wd_rst_pulse (wd_rst_pulse)
);

// File: tb/tb_kwd_top.sv
`timescale 1ns/1ps
module tb_kwd_top;
    localparam int T   = 20;
    localparam int PL  = 16;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wd_rst_pulse;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    kwd_top #(.TIMEOUT(T), .PULSE_LEN(PL)) dut (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wd_rst_pulse(wd_rst_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the capture edge
    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_sys_rst();
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        while (!wd_rst_pulse && n < 4 * T) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic drain_pulse(input bit hit_rst, output int m);
        m = 0;
        if (hit_rst) sys_rst = 1'b1;
        while (wd_rst_pulse && m < 4 * PL) begin
            @(negedge clk);
            sys_rst = 1'b0;
            m++;
        end
        sys_rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n, m;

        repeat (3) @(negedge clk);
        rd(1'b0, v);
        check("R2 ctrl after por", v, 0);
        check("R2 pulse after por", wd_rst_pulse, 0);
        por_n = 1'b1;
        @(negedge clk);

        // R3: enable alone
        wr(1'b0, 8'h01);
        wait_pulse(n);
        check("R3 enable to pulse", n, T + 1);
        rd(1'b0, v);
        check("R8 flag at pulse start", v[1], 1);
        drain_pulse(1'b1, m);
        check("R7 pulse length with sys_rst", m, PL);
        rd(1'b0, v);
        check("R10 enable cleared, R9 flag kept", v, 8'h02);
        rd(1'b1, v);
        check("R1 restart reads zero", v, 0);
        wr(1'b0, 8'h02);
        rd(1'b0, v);
        check("R9 write bit1=1 keeps flag", v, 8'h02);
        wr(1'b0, 8'h00);
        rd(1'b0, v);
        check("R9 write bit1=0 clears flag", v, 0);
        wr(1'b0, 8'h02);
        rd(1'b0, v);
        check("R9 write bit1=1 never sets", v, 0);

        // R4: disabled, and disable mid-count
        repeat (3 * T) @(negedge clk);
        check("R4 no pulse while off", wd_rst_pulse, 0);
        wr(1'b0, 8'h01);
        repeat (T / 2) @(negedge clk);
        wr(1'b0, 8'h00);
        m = 0;
        for (int i = 0; i < 3 * T; i++) begin
            @(negedge clk);
            if (wd_rst_pulse) m++;
        end
        check("R4 disable stops count", m, 0);
        wr(1'b0, 8'h01);
        wait_pulse(n);
        check("R4 re-enable reloads", n, T + 1);
        drain_pulse(1'b1, m);
        wr(1'b0, 8'h00);

        // R5/R6 sweep of the second key byte
        for (int b = 0; b < 256; b++) begin
            wr(1'b0, 8'h01);
            wr(1'b1, 8'h1E);
            wr(1'b1, 8'(b));
            wait_pulse(n);
            if (b == 8'hE1) check("R5 valid key reload", n, T + 1);
            else            check("R6 wrong second byte no reload", n, T - 1);
            drain_pulse(1'b1, m);
            check("R7 pulse length sweep", m, PL);
            rd(1'b0, v);
            check("R1 ctrl readback after timeout", v, 8'h02);
            wr(1'b0, 8'h00);
        end

        // R6 sweep of a lone first byte: only 0x1E arms, nothing reloads
        for (int b = 0; b < 256; b++) begin
            wr(1'b0, 8'h01);
            wr(1'b1, 8'(b));
            wait_pulse(n);
            check("R6 single byte no reload", n, T);
            drain_pulse(1'b1, m);
            wr(1'b0, 8'h00);
        end

        // R6: 1E,1E,E1
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        wait_pulse(n);
        check("R6 double first key disarms", n, T - 2);
        drain_pulse(1'b1, m);
        wr(1'b0, 8'h00);

        // R5: repeated valid restarts keep it alive
        wr(1'b0, 8'h01);
        m = 0;
        for (int k = 0; k < 6; k++) begin
            repeat (T / 2) @(negedge clk);
            if (wd_rst_pulse) m++;
            wr(1'b1, 8'h1E);
            wr(1'b1, 8'hE1);
        end
        check("R5 kept alive by keys", m, 0);
        wait_pulse(n);
        check("R5 last key reload", n, T + 1);
        drain_pulse(1'b1, m);
        wr(1'b0, 8'h00);

        // R10: armed key discarded by sys_rst
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h1E);
        pulse_sys_rst();
        wr(1'b0, 8'h01);
        wr(1'b1, 8'hE1);
        wait_pulse(n);
        check("R10 sys_rst drops armed key", n, T);
        drain_pulse(1'b1, m);
        wr(1'b0, 8'h00);

        // R11: keys during pulse ignored, refire after one low cycle
        wr(1'b0, 8'h01);
        wait_pulse(n);
        wr(1'b1, 8'h1E);
        wr(1'b1, 8'hE1);
        wr(1'b0, 8'h01);
        drain_pulse(1'b0, m);
        check("R11 first pulse length", m, PL - 3);
        check("R11 gap cycle low", wd_rst_pulse, 0);
        @(negedge clk);
        check("R11 refire after gap", wd_rst_pulse, 1);
        drain_pulse(1'b1, m);
        check("R7 refire pulse length", m, PL);

        // R9: power-on reset clears flag
        rd(1'b0, v);
        check("R9 flag before por", v[1], 1);
        por_n = 1'b0;
        rd(1'b0, v);
        check("R9 por clears flag", v, 0);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule